// File: doc/BRIEF.md
# General-Purpose Event Timer

This block is a 32-bit up-counting timer that sits behind a simple register bus. Its count source is the functional clock. An optional power-of-two prescaler can divide that clock. When the count rolls past all-ones, the counter either reloads from a load register or wraps to zero. While it counts, it compares its value against a match register. An edge on the capture pin latches the current count.

Three event flags, for match, overflow and capture, are collected in a write-one-to-clear status register. An enable mask turns them into a single interrupt line. One output pin can do three jobs:
- follow a static software level;
- pulse for one cycle on selected events;
- toggle on selected events.

Software can copy the load value into the counter at any moment by writing the trigger register. A write to the interface-control register starts a soft reset. During the reset window all registers are cleared and bus writes are ignored. A status bit reports when the window is over.

Top module: `gp_timer`

## Requirements
- R1: After the asynchronous reset every register reads 0, pwm_o and irq_o are 0, and bit 0 of the system-status register (offset 0x24) reads 1. Reads at unmapped offsets return 0.
- R2: While control bit 0 (offset 0x00) is set, the counter (offset 0x04) advances by one on each count tick. While it is clear, the counter holds its value.
- R3: With control bit 5 set, a count tick occurs once every 2^(P+1) clocks, where P is control bits 4:2. With bit 5 clear, a tick occurs on every clock while running.
- R4: A tick at count 0xFFFFFFFF sets status bit 1. The counter then loads the load register (offset 0x08) when control bit 1 is set, and becomes 0 otherwise.
- R5: A bus write of any value to the trigger register (offset 0x0C) copies the load register into the counter on the next edge. A bus write to offset 0x04 sets the counter to the written value.
- R6: With control bit 6 set, a tick that brings the counter to the match register value (offset 0x10) sets status bit 0. With bit 6 clear, that bit is not set.
- R7: Control bits 9:8 choose the capture edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge on capt_i sets status bit 2 and copies the current count into the capture register (offset 0x14). With control bit 13 set, the copy happens only while status bit 2 is clear.
- R8: Control bits 11:10 choose the output events: 00 none (pwm_o holds the default level), 01 overflow, 10 or 11 overflow or match. Control bit 7 is the default level. With control bit 12 set, pwm_o toggles on each event. With bit 12 clear, pwm_o shows the inverted default level for one cycle after each event.
- R9: With control bit 14 set, pwm_o follows control bit 7 one cycle later, whatever the event settings.
- R10: Writing 1 to a bit of the status register (offset 0x18) clears it. Bits written with 0 are unaffected. An event in the same cycle as the clearing write wins.
- R11: irq_o is high exactly when some status bit is set and its bit in the enable register (offset 0x1C) is set.
- R12: A write with bit 1 set to the interface-control register (offset 0x20) clears all registers and the output pin. For the next RST_CYC cycles (default 4), system-status bit 0 reads 0 and bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr_i | input | AW | Byte offset of the register |
| bus_wdata_i | input | W | Write data |
| bus_rdata_o | output | W | Read data for bus_addr_i, combinational |
| capt_i | input | 1 | Capture input, synchronous to clk_i |
| pwm_o | output | 1 | Event / level output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- the counter holds when no tick, write or trigger occurs;
- an overflow reloads or wraps correctly;
- a trigger lands the load value;
- the prescaler never fires on back-to-back cycles;
- the capture register is stable without an edge;
- the output pin follows the default level in level mode and between pulses;
- status clearing and event priority behave as required;
- the reset window keeps the registers cleared.

Other properties only the bench scenarios can show, by comparing with a behavioural model on every clock:
- exact tick counts under each prescale setting;
- match detection;
- capture edge selection and hold-first mode;
- toggle sequences across overflow and match;
- the length of the soft reset window.

// File: rtl/gp_timer_pkg.sv
`timescale 1ns/1ps
package gp_timer_pkg;
  localparam int unsigned CTRL_W = 15;
  localparam int unsigned PTV_W  = 3;
  localparam int unsigned EVT_W  = 3;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h04;
  localparam logic [7:0] OFS_LOAD  = 8'h08;
  localparam logic [7:0] OFS_TRIG  = 8'h0C;
  localparam logic [7:0] OFS_MATCH = 8'h10;
  localparam logic [7:0] OFS_CAPT  = 8'h14;
  localparam logic [7:0] OFS_STAT  = 8'h18;
  localparam logic [7:0] OFS_IEN   = 8'h1C;
  localparam logic [7:0] OFS_IFC   = 8'h20;
  localparam logic [7:0] OFS_SYS   = 8'h24;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_AR    = 1;
  localparam int unsigned CB_PTV   = 2;
  localparam int unsigned CB_PRE   = 5;
  localparam int unsigned CB_CE    = 6;
  localparam int unsigned CB_DEF   = 7;
  localparam int unsigned CB_EDGE  = 8;
  localparam int unsigned CB_TRG   = 10;
  localparam int unsigned CB_TOG   = 12;
  localparam int unsigned CB_HOLD  = 13;
  localparam int unsigned CB_LEVEL = 14;

  localparam int unsigned EV_MATCH = 0;
  localparam int unsigned EV_OVF   = 1;
  localparam int unsigned EV_CAPT  = 2;

  localparam int unsigned IFC_SRST = 1;

  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_sel_e;
  typedef enum logic [1:0] {TRG_NONE, TRG_OVF, TRG_OVF_MATCH, TRG_OVF_MATCH_ALT} trg_sel_e;
endpackage

// File: rtl/gp_timer_presc.sv
`timescale 1ns/1ps
module gp_timer_presc #(
  parameter int unsigned PTV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             pre_en_i,
  input  logic [PTV_W-1:0] ptv_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = 2 ** PTV_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic             at_lim;

  // terminal count = 2^(ptv+1)-1
  assign lim    = ~({DIV_W{1'b1}} << ({1'b0, ptv_i} + (PTV_W+1)'(1)));
  assign at_lim = (div_q == lim);
  assign tick_o = run_i & (~pre_en_i | at_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  div_q <= '0;
    else if (clr_i || !run_i || !pre_en_i || at_lim) div_q <= '0;
    else                                          div_q <= div_q + DIV_W'(1);
  end

  AST_PRESC_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && pre_en_i) |=> !(tick_o && pre_en_i)); // R3
endmodule

// File: rtl/gp_timer_core.sv
`timescale 1ns/1ps
module gp_timer_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic         ar_i,
  input  logic         ce_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] match_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         trig_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q, cnt_nxt;

  assign ovf_o   = tick_i & (&cnt_q);
  assign cnt_nxt = ovf_o ? (ar_i ? load_i : '0) : cnt_q + W'(1);
  assign match_o = tick_i & ce_i & (cnt_nxt == match_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= cnt_wdata_i;
    else if (trig_i)   cnt_q <= load_i;
    else if (tick_i)   cnt_q <= cnt_nxt;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr_i && !trig_i && !clr_i) |=> $stable(cnt_o)); // R2
  AST_OVF_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && ar_i && !cnt_wr_i && !trig_i && !clr_i) |=> cnt_o == $past(load_i)); // R4
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ar_i && !cnt_wr_i && !trig_i && !clr_i) |=> cnt_o == '0); // R4
  AST_TRIG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !cnt_wr_i && !clr_i) |=> cnt_o == $past(load_i)); // R5
endmodule

// File: rtl/gp_timer_capt.sv
`timescale 1ns/1ps
module gp_timer_capt
  import gp_timer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  edge_sel_e    edge_sel_i,
  input  logic         hold_first_i,
  input  logic         pending_i,
  input  logic         pin_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] capt_o,
  output logic         evt_o
);
  logic         pin_q;
  logic [W-1:0] capt_q;

  always_comb begin
    case (edge_sel_i)
      EDGE_RISE: evt_o =  pin_i & ~pin_q;
      EDGE_FALL: evt_o = ~pin_i &  pin_q;
      EDGE_BOTH: evt_o =  pin_i ^  pin_q;
      default:   evt_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    capt_q <= '0;
    else if (clr_i)                                 capt_q <= '0;
    else if (evt_o && (!hold_first_i || !pending_i)) capt_q <= cnt_i;
  end

  assign capt_o = capt_q;

  AST_CAPT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_o && !clr_i) |=> $stable(capt_o)); // R7
endmodule

// File: rtl/gp_timer_pwm.sv
`timescale 1ns/1ps
module gp_timer_pwm
  import gp_timer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     level_mode_i,
  input  logic     def_i,
  input  logic     toggle_i,
  input  trg_sel_e trg_sel_i,
  input  logic     ovf_i,
  input  logic     match_i,
  output logic     pwm_o
);
  logic pwm_q, evt;

  assign evt = ((trg_sel_i != TRG_NONE) & ovf_i) | (trg_sel_i[1] & match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pwm_q <= 1'b0;
    else if (clr_i)                  pwm_q <= 1'b0;
    else if (level_mode_i)           pwm_q <= def_i;
    else if (trg_sel_i == TRG_NONE)  pwm_q <= def_i;
    else if (toggle_i)               pwm_q <= evt ? ~pwm_q : pwm_q;
    else                             pwm_q <= evt ? ~def_i : def_i;
  end

  assign pwm_o = pwm_q;

  AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_mode_i && !clr_i) |=> pwm_o == $past(def_i)); // R9
  AST_PULSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_mode_i && !toggle_i && !evt && !clr_i) |=> pwm_o == $past(def_i)); // R8
endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned AW      = 8,
  parameter int unsigned RST_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [W-1:0]  bus_wdata_i,
  output logic [W-1:0]  bus_rdata_o,
  input  logic          capt_i,
  output logic          pwm_o,
  output logic          irq_o
);
  localparam int unsigned SRW = $clog2(RST_CYC + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      load_q, match_q, cnt, capt_val;
  logic [EVT_W-1:0]  stat_q, ien_q, evts, w1c;
  logic [SRW-1:0]    srst_q;
  logic busy, wr_ok, clr, srst_req;
  logic wr_ctrl, wr_cnt, wr_load, wr_trig, wr_match, wr_stat, wr_ien, wr_ifc;
  logic tick, ovf, mtch, cap_evt;

  assign busy  = (srst_q != '0);
  assign wr_ok = bus_we_i & ~busy;

  assign wr_ctrl  = wr_ok & (bus_addr_i == AW'(OFS_CTRL));
  assign wr_cnt   = wr_ok & (bus_addr_i == AW'(OFS_COUNT));
  assign wr_load  = wr_ok & (bus_addr_i == AW'(OFS_LOAD));
  assign wr_trig  = wr_ok & (bus_addr_i == AW'(OFS_TRIG));
  assign wr_match = wr_ok & (bus_addr_i == AW'(OFS_MATCH));
  assign wr_stat  = wr_ok & (bus_addr_i == AW'(OFS_STAT));
  assign wr_ien   = wr_ok & (bus_addr_i == AW'(OFS_IEN));
  assign wr_ifc   = wr_ok & (bus_addr_i == AW'(OFS_IFC));

  assign srst_req = wr_ifc & bus_wdata_i[IFC_SRST];
  assign clr      = busy | srst_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       srst_q <= '0;
    else if (srst_req) srst_q <= SRW'(RST_CYC);
    else if (busy)     srst_q <= srst_q - SRW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
    end else if (clr) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= bus_wdata_i[CTRL_W-1:0];
      if (wr_load)  load_q  <= bus_wdata_i;
      if (wr_match) match_q <= bus_wdata_i;
      if (wr_ien)   ien_q   <= bus_wdata_i[EVT_W-1:0];
    end
  end

  gp_timer_presc #(.PTV_W(PTV_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .run_i    (ctrl_q[CB_RUN]),
    .pre_en_i (ctrl_q[CB_PRE]),
    .ptv_i    (ctrl_q[CB_PTV +: PTV_W]),
    .tick_o   (tick)
  );

  gp_timer_core #(.W(W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .tick_i      (tick),
    .ar_i        (ctrl_q[CB_AR]),
    .ce_i        (ctrl_q[CB_CE]),
    .load_i      (load_q),
    .match_i     (match_q),
    .cnt_wr_i    (wr_cnt),
    .cnt_wdata_i (bus_wdata_i),
    .trig_i      (wr_trig),
    .cnt_o       (cnt),
    .ovf_o       (ovf),
    .match_o     (mtch)
  );

  gp_timer_capt #(.W(W)) u_capt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .edge_sel_i   (edge_sel_e'(ctrl_q[CB_EDGE +: 2])),
    .hold_first_i (ctrl_q[CB_HOLD]),
    .pending_i    (stat_q[EV_CAPT]),
    .pin_i        (capt_i),
    .cnt_i        (cnt),
    .capt_o       (capt_val),
    .evt_o        (cap_evt)
  );

  gp_timer_pwm u_pwm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .level_mode_i (ctrl_q[CB_LEVEL]),
    .def_i        (ctrl_q[CB_DEF]),
    .toggle_i     (ctrl_q[CB_TOG]),
    .trg_sel_i    (trg_sel_e'(ctrl_q[CB_TRG +: 2])),
    .ovf_i        (ovf),
    .match_i      (mtch),
    .pwm_o        (pwm_o)
  );

  always_comb begin
    evts           = '0;
    evts[EV_MATCH] = mtch;
    evts[EV_OVF]   = ovf;
    evts[EV_CAPT]  = cap_evt;
  end

  assign w1c = wr_stat ? bus_wdata_i[EVT_W-1:0] : '0;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (clr)   stat_q <= '0;
    else            stat_q <= (stat_q & ~w1c) | evts;
  end

  assign irq_o = |(stat_q & ien_q);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      AW'(OFS_CTRL):  bus_rdata_o = W'(ctrl_q);
      AW'(OFS_COUNT): bus_rdata_o = cnt;
      AW'(OFS_LOAD):  bus_rdata_o = load_q;
      AW'(OFS_MATCH): bus_rdata_o = match_q;
      AW'(OFS_CAPT):  bus_rdata_o = capt_val;
      AW'(OFS_STAT):  bus_rdata_o = W'(stat_q);
      AW'(OFS_IEN):   bus_rdata_o = W'(ien_q);
      AW'(OFS_SYS):   bus_rdata_o = W'(!busy);
      default:        bus_rdata_o = '0;
    endcase
  end

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && bus_wdata_i[EV_OVF] && !ovf && !clr) |=> !stat_q[EV_OVF]); // R10
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !clr) |=> stat_q[EV_OVF]); // R10
  AST_SRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (ctrl_q == '0 && stat_q == '0 && !pwm_o)); // R12
endmodule

// File: tb/gp_timer_test.sv
`timescale 1ns/1ps
module gp_timer_test;
  localparam int RST_CYC = 4;
  localparam bit [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_LOAD = 8'h08, A_TRIG = 8'h0C,
                       A_MATCH = 8'h10, A_CAPT = 8'h14, A_STAT = 8'h18, A_IEN = 8'h1C,
                       A_IFC = 8'h20, A_SYS = 8'h24;
  localparam bit [31:0] ST = 1, AR = 2, PRE = 32'h20, CE = 32'h40, DEF = 32'h80,
                        E_RISE = 32'h100, E_FALL = 32'h200, E_BOTH = 32'h300,
                        T_OVF = 32'h400, T_OVFM = 32'h800, TOG = 32'h1000,
                        HOLD = 32'h2000, LVL = 32'h4000;

  logic clk = 0, rst_n = 0, we = 0, capt = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic pwm, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gp_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .capt_i(capt), .pwm_o(pwm), .irq_o(irq)
  );

  // behavioural reference
  bit [31:0] m_cnt, m_load, m_match, m_capt, nxt;
  bit [14:0] m_ctrl;
  bit [2:0]  m_stat, m_ien, evs;
  int m_psc, m_srst, lim;
  bit m_pwm, m_capq, tick, ovf, mt, cev, pe, clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_match = 0; m_capt = 0; m_ctrl = 0; m_stat = 0;
      m_ien = 0; m_psc = 0; m_srst = 0; m_pwm = 0; m_capq = 0;
    end else begin
      clr = (m_srst != 0) || (we && addr == A_IFC && wdata[1]);
      tick = 0;
      lim = (2 << m_ctrl[4:2]) - 1;
      if (m_ctrl[0]) tick = !m_ctrl[5] || (m_psc == lim);
      ovf = tick && (m_cnt == 32'hFFFF_FFFF);
      nxt = ovf ? (m_ctrl[1] ? m_load : 0) : m_cnt + 1;
      mt  = tick && m_ctrl[6] && (nxt == m_match);
      case (m_ctrl[9:8])
        2'b01: cev = capt && !m_capq;
        2'b10: cev = !capt && m_capq;
        2'b11: cev = capt != m_capq;
        default: cev = 0;
      endcase
      pe = ((m_ctrl[11:10] != 0) && ovf) || (m_ctrl[11] && mt);
      if (clr) begin
        m_cnt = 0; m_load = 0; m_match = 0; m_capt = 0; m_ctrl = 0; m_stat = 0;
        m_ien = 0; m_psc = 0; m_pwm = 0;
        m_srst = (m_srst != 0) ? m_srst - 1 : RST_CYC;
      end else begin
        if (!m_ctrl[0] || !m_ctrl[5] || tick) m_psc = 0; else m_psc = (m_psc + 1) & 255;
        if (m_ctrl[14] || m_ctrl[11:10] == 0) m_pwm = m_ctrl[7];
        else if (m_ctrl[12]) m_pwm = pe ? !m_pwm : m_pwm;
        else m_pwm = pe ? !m_ctrl[7] : m_ctrl[7];
        if (cev && (!m_ctrl[13] || !m_stat[2])) m_capt = m_cnt;
        evs = {cev, ovf, mt};
        m_stat = (m_stat & ~((we && addr == A_STAT) ? wdata[2:0] : 3'b0)) | evs;
        if (we && addr == A_CNT) m_cnt = wdata;
        else if (we && addr == A_TRIG) m_cnt = m_load;
        else if (tick) m_cnt = nxt;
        if (we && addr == A_CTRL)  m_ctrl  = wdata[14:0];
        if (we && addr == A_LOAD)  m_load  = wdata;
        if (we && addr == A_MATCH) m_match = wdata;
        if (we && addr == A_IEN)   m_ien   = wdata[2:0];
      end
      m_capq = capt;
    end
  end

  function automatic bit [31:0] exp_rd(bit [7:0] a);
    case (a)
      A_CTRL:  return {17'b0, m_ctrl};
      A_CNT:   return m_cnt;
      A_LOAD:  return m_load;
      A_MATCH: return m_match;
      A_CAPT:  return m_capt;
      A_STAT:  return {29'b0, m_stat};
      A_IEN:   return {29'b0, m_ien};
      A_SYS:   return {31'b0, m_srst == 0};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R8 pwm_o vs model", {31'b0, pwm}, {31'b0, m_pwm});
    chk("R11 irq_o vs model", {31'b0, irq}, {31'b0, |(m_stat & m_ien)});
  end

  task automatic wr(bit [7:0] a, bit [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(bit [7:0] a, string tag, output logic [31:0] v);
    addr = a; #1;
    v = rdata;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(bit v);
    @(negedge clk); capt = v;
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    foreach (A_LIST[i]) begin
      addr = A_LIST[i]; #1;
      chk("R1 reset value", rdata, (A_LIST[i] == A_SYS) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
    chk("R1 pwm reset", {31'b0, pwm}, 0);
    chk("R1 irq reset", {31'b0, irq}, 0);
    addr = 8'h3C; #1; chk("R1 unmapped", rdata, 0);

    // R2 run / hold
    wr(A_CNT, 10); wr(A_CTRL, ST); idle(5);
    rd(A_CNT, "R2 running", v);
    wr(A_CTRL, 0); rd(A_CNT, "R2 stopped", v1); idle(3);
    rd(A_CNT, "R2 held", v); chk("R2 hold literal", v, v1);

    // R3 prescaler
    wr(A_CNT, 0); wr(A_CTRL, ST | PRE | (2 << 2)); idle(41);
    rd(A_CNT, "R3 div8", v);
    wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_CTRL, ST | PRE | (7 << 2)); idle(700);
    rd(A_CNT, "R3 div256", v); chk("R3 div256 range", {31'b0, v == 2 || v == 3}, 1);
    wr(A_CTRL, ST | PRE); idle(9); rd(A_CNT, "R3 div2", v);

    // R4 overflow with reload, pulse on overflow
    wr(A_CTRL, 0); wr(A_LOAD, 32'h100); wr(A_CNT, 32'hFFFF_FFFD);
    wr(A_CTRL, ST | AR | T_OVF); idle(6);
    rd(A_CNT, "R4 reload", v); rd(A_STAT, "R4 status", v); chk("R4 ovf bit", {31'b0, v[1]}, 1);
    wr(A_CTRL, 0); wr(A_STAT, 7); rd(A_STAT, "R10 w1c", v); chk("R10 cleared", v, 0);
    wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTRL, ST); idle(3); wr(A_CTRL, 0);
    rd(A_CNT, "R4 wrap", v); chk("R4 wrap small", {31'b0, v < 8}, 1);

    // R5 trigger and direct write
    wr(A_LOAD, 32'h1234); wr(A_TRIG, 32'hDEAD);
    rd(A_CNT, "R5 trigger", v); chk("R5 trigger literal", v, 32'h1234);
    wr(A_CNT, 32'h55); rd(A_CNT, "R5 write", v); chk("R5 write literal", v, 32'h55);

    // R6 match, R11 irq, R10 partial clear
    wr(A_STAT, 7); wr(A_IEN, 1); wr(A_MATCH, 32'h60); wr(A_CNT, 32'h50); wr(A_CTRL, ST | CE);
    idle(30); rd(A_STAT, "R6 match", v); chk("R6 match bit", {31'b0, v[0]}, 1);
    chk("R11 irq high", {31'b0, irq}, 1);
    wr(A_CTRL, 0); wr(A_STAT, 2); rd(A_STAT, "R10 other bit kept", v);
    chk("R10 match kept", {31'b0, v[0]}, 1);
    wr(A_STAT, 1); chk("R11 irq low", {31'b0, irq}, 0);
    wr(A_CNT, 32'h50); wr(A_CTRL, ST); idle(30); wr(A_CTRL, 0);
    rd(A_STAT, "R6 disabled", v); chk("R6 no match bit", {31'b0, v[0]}, 0);

    // R8 toggle on overflow+match, then pulse with default high
    wr(A_STAT, 7); wr(A_IEN, 7); wr(A_LOAD, 32'hFFFF_FFF8); wr(A_MATCH, 32'hFFFF_FFFC);
    wr(A_CNT, 32'hFFFF_FFF8); wr(A_CTRL, ST | AR | CE | T_OVFM | TOG); idle(40);
    wr(A_CTRL, ST | AR | CE | T_OVFM | DEF); idle(40);
    wr(A_CTRL, ST | AR | CE | T_OVF); idle(40);

    // R9 level mode
    wr(A_CTRL, LVL | DEF | T_OVFM | ST | AR); idle(2); chk("R9 level high", {31'b0, pwm}, 1);
    wr(A_CTRL, LVL | T_OVFM | ST | AR); idle(2); chk("R9 level low", {31'b0, pwm}, 0);

    // R7 capture
    wr(A_CTRL, 0); wr(A_STAT, 7); wr(A_CNT, 0); wr(A_CTRL, ST | E_RISE); idle(5);
    pin(1); idle(3); rd(A_CAPT, "R7 rising", v); rd(A_STAT, "R7 status", v);
    chk("R7 capt bit", {31'b0, v[2]}, 1);
    wr(A_CTRL, ST | E_FALL); pin(0); idle(2); pin(1); idle(4); rd(A_CAPT, "R7 falling", v);
    wr(A_CTRL, ST | E_RISE); pin(0); idle(3); pin(1); idle(2); rd(A_CAPT, "R7 rise again", v);
    wr(A_STAT, 7); wr(A_CTRL, ST | E_BOTH | HOLD); pin(0); idle(4);
    rd(A_CAPT, "R7 hold first", v1); pin(1); idle(4);
    rd(A_CAPT, "R7 held", v); chk("R7 held literal", v, v1);
    wr(A_STAT, 4); pin(0); idle(2); rd(A_CAPT, "R7 after clear", v);

    // R12 soft reset
    wr(A_CTRL, ST | DEF | LVL); wr(A_IEN, 7); wr(A_LOAD, 5);
    wr(A_IFC, 2);
    rd(A_SYS, "R12 busy", v); chk("R12 busy literal", v, 0);
    rd(A_CTRL, "R12 ctrl cleared", v); chk("R12 ctrl literal", v, 0);
    wr(A_LOAD, 9); idle(5);
    rd(A_SYS, "R12 done", v); chk("R12 done literal", v, 1);
    rd(A_LOAD, "R12 write ignored", v); chk("R12 load literal", v, 0);
    chk("R12 pwm cleared", {31'b0, pwm}, 0);

    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam bit [7:0] A_LIST [10] = '{A_CTRL, A_CNT, A_LOAD, A_TRIG, A_MATCH, A_CAPT,
                                       A_STAT, A_IEN, A_IFC, A_SYS};
endmodule